// File: doc/BRIEF.md
# Prefetching Outbound Read Bridge

This block is a 32-bit slave on a local processor bus. It forwards reads to an external bus that can return either one word or a burst of words. Each local request carries a flag that marks its address region as prefetchable or not. A processor that reads 64 bits at a time reaches this slave as two 32-bit requests in a row, one after the other.

A read to a non-prefetchable region always goes out as a single-word external read. The data comes back to the requester when it arrives. A read to a prefetchable region is first checked against a single 64-byte line buffer. The buffer holds a valid bit and the address bits above the 64-byte boundary. On a hit, the word is returned from the buffer and nothing happens on the external bus. On a miss, the block fetches the whole line as a burst that starts at the line-aligned address. It hands the requested word back as soon as that beat arrives, keeps filling the rest of the line, and then marks the line valid. A non-prefetchable access clears the valid bit. So does a write strobe seen on the local side, even one that arrives during a fill. This way stale data is never served.

The local side pulses `lcl_req` for one cycle while `lcl_busy` is low. It receives exactly one `lcl_ack` with `lcl_rdata` for each request. Bits [1:0] of every address are ignored.

Top module: `pf_read_bridge`

## Requirements
- R1: After reset, `lcl_busy`, `lcl_ack` and `ext_req` are low and the line buffer is invalid, so the first prefetchable read misses.
- R2: A non-prefetchable request issues exactly one external read with `ext_len` = 1 at the word-aligned request address. The returned word goes back to the requester. `ext_len` only ever takes the values 1 and 16.
- R3: A prefetchable request that misses issues one external burst with `ext_len` = 16 at the request address with bits [5:0] cleared.
- R4: During a line fill, `lcl_ack` rises one cycle after the `ext_rvalid` beat whose index (address bits [5:2]) equals the requested word, and carries that beat's data.
- R5: A prefetchable request whose address bits [31:6] match a valid buffered line is acknowledged on the next cycle with the buffered word, and no external request is made.
- R6: A prefetchable request to a different line misses and refills the buffer. Eight 64-bit reads (sixteen requests) within one line cause one burst in total.
- R7: A non-prefetchable request clears the buffer valid bit, so the next prefetchable read refetches its line.
- R8: A pulse on `lcl_wr_strobe` clears the valid bit. A pulse during a fill leaves the filled line invalid.
- R9: Once raised, `ext_req`, `ext_addr` and `ext_len` stay constant until the cycle in which `ext_gnt` is high.
- R10: Every accepted request gets exactly one `lcl_ack`. `lcl_busy` is high from the cycle after a miss or a non-prefetchable request is accepted until its external read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lcl_req | input | 1 | One-cycle read request, legal while lcl_busy is low |
| lcl_addr | input | 32 | Byte address of the requested word |
| lcl_pref | input | 1 | Region of this request is prefetchable |
| lcl_wr_strobe | input | 1 | A local write occurred; invalidates the buffer |
| lcl_busy | output | 1 | An external read is pending |
| lcl_ack | output | 1 | Read data valid, one pulse per request |
| lcl_rdata | output | 32 | Read data |
| ext_req | output | 1 | External read request |
| ext_addr | output | 32 | External start address |
| ext_len | output | 5 | Number of words requested (1 or 16) |
| ext_gnt | input | 1 | External bus accepted the request |
| ext_rvalid | input | 1 | External read beat valid |
| ext_rdata | input | 32 | External read beat data |

## Verification
The embedded properties hold the external request stable until it is granted. They also check that burst addresses are line-aligned, that lengths are legal, that a hit is acknowledged with no external activity, that an acknowledge after a fill is preceded by a beat, and that the valid bit drops after a non-prefetchable access or a write strobe. Other behaviour cannot be expressed as a per-cycle property: only the bench's scenarios show it. This covers whether the returned data belongs to the requested word, whether sixteen requests within a line really cost one burst, and whether a write during a fill forces a later refetch that returns fresh data rather than stale data.

// File: rtl/pf_read_bridge.sv
module pf_read_bridge #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lcl_req,
  input  logic [ADDR_W-1:0] lcl_addr,
  input  logic              lcl_pref,
  input  logic              lcl_wr_strobe,
  output logic              lcl_busy,
  output logic              lcl_ack,
  output logic [31:0]       lcl_rdata,
  output logic              ext_req,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [$clog2(LINE_BYTES/4+1)-1:0] ext_len,
  input  logic              ext_gnt,
  input  logic              ext_rvalid,
  input  logic [31:0]       ext_rdata
);

  localparam int WORDS = LINE_BYTES / 4;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int LEN_W = $clog2(WORDS + 1);

  typedef enum logic [2:0] {IDLE, SREQ, SWAIT, LREQ, LFILL} st_t;

  st_t              state;
  logic [31:0]      line_q [WORDS];
  logic [TAG_W-1:0] tag_q;
  logic             vld_q;
  logic             kill_q;
  logic [IDX_W-1:0] want_q;
  logic [IDX_W-1:0] cnt_q;

  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic             accept;
  logic             hit;

  assign req_tag  = lcl_addr[ADDR_W-1:OFF_W];
  assign req_idx  = lcl_addr[OFF_W-1:2];
  assign accept   = lcl_req && (state == IDLE);
  assign hit      = vld_q && (tag_q == req_tag) && !lcl_wr_strobe;
  assign lcl_busy = (state != IDLE);

  always_ff @(posedge clk) begin
    if (state == LFILL && ext_rvalid)
      line_q[cnt_q] <= ext_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      tag_q     <= '0;
      vld_q     <= 1'b0;
      kill_q    <= 1'b0;
      want_q    <= '0;
      cnt_q     <= '0;
      lcl_ack   <= 1'b0;
      lcl_rdata <= '0;
      ext_req   <= 1'b0;
      ext_addr  <= '0;
      ext_len   <= '0;
    end else begin
      lcl_ack <= 1'b0;
      case (state)
        IDLE: if (accept) begin
          if (!lcl_pref) begin
            vld_q    <= 1'b0;
            ext_req  <= 1'b1;
            ext_addr <= {lcl_addr[ADDR_W-1:2], 2'b00};
            ext_len  <= LEN_W'(1);
            state    <= SREQ;
          end else if (hit) begin
            lcl_ack   <= 1'b1;
            lcl_rdata <= line_q[req_idx];
          end else begin
            vld_q    <= 1'b0;
            kill_q   <= 1'b0;
            tag_q    <= req_tag;
            want_q   <= req_idx;
            cnt_q    <= '0;
            ext_req  <= 1'b1;
            ext_addr <= {req_tag, {OFF_W{1'b0}}};
            ext_len  <= LEN_W'(WORDS);
            state    <= LREQ;
          end
        end
        SREQ: if (ext_gnt) begin
          ext_req <= 1'b0;
          state   <= SWAIT;
        end
        SWAIT: if (ext_rvalid) begin
          lcl_ack   <= 1'b1;
          lcl_rdata <= ext_rdata;
          state     <= IDLE;
        end
        LREQ: if (ext_gnt) begin
          ext_req <= 1'b0;
          state   <= LFILL;
        end
        LFILL: if (ext_rvalid) begin
          if (cnt_q == want_q) begin
            lcl_ack   <= 1'b1;
            lcl_rdata <= ext_rdata;
          end
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == IDX_W'(WORDS - 1)) begin
            vld_q <= !kill_q && !lcl_wr_strobe;
            state <= IDLE;
          end
        end
        default: state <= IDLE;
      endcase
      if (lcl_wr_strobe) begin
        vld_q  <= 1'b0;
        kill_q <= 1'b1;
      end
    end
  end

  AST_EXT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_gnt |=> ext_req && $stable(ext_addr) && $stable(ext_len)); // R9
  AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && ext_len != LEN_W'(1) |-> ext_addr[OFF_W-1:0] == '0); // R3
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req |-> (ext_len == LEN_W'(1) || ext_len == LEN_W'(WORDS))); // R2
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    accept && lcl_pref && hit |=> lcl_ack && !ext_req && !lcl_busy); // R5
  AST_ACK_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_ack && !$past(accept) |-> $past(ext_rvalid)); // R4
  AST_NPREF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !lcl_pref |=> !vld_q); // R7
  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_wr_strobe |=> !vld_q); // R8
  AST_MISS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !(lcl_pref && hit) |=> lcl_busy && ext_req); // R10

endmodule

// File: tb/pf_read_bridge_bench.sv
module pf_read_bridge_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lcl_req = 1'b0;
  logic [31:0] lcl_addr = '0;
  logic        lcl_pref = 1'b0;
  logic        lcl_wr_strobe = 1'b0;
  logic        lcl_busy, lcl_ack;
  logic [31:0] lcl_rdata;
  logic        ext_req;
  logic [31:0] ext_addr;
  logic [4:0]  ext_len;
  logic        ext_gnt = 1'b0;
  logic        ext_rvalid = 1'b0;
  logic [31:0] ext_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_read_bridge u_pf_read_bridge (
    .clk(clk), .rst_n(rst_n), .lcl_req(lcl_req), .lcl_addr(lcl_addr),
    .lcl_pref(lcl_pref), .lcl_wr_strobe(lcl_wr_strobe), .lcl_busy(lcl_busy),
    .lcl_ack(lcl_ack), .lcl_rdata(lcl_rdata), .ext_req(ext_req),
    .ext_addr(ext_addr), .ext_len(ext_len), .ext_gnt(ext_gnt),
    .ext_rvalid(ext_rvalid), .ext_rdata(ext_rdata));

  int total = 0;
  int bad = 0;
  int ntx = 0;
  int acks = 0;
  int reqs = 0;
  logic [7:0]  gen = 8'd1;
  logic [31:0] last_addr = '0;
  logic [4:0]  last_len = '0;
  logic        done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [31:0] mem(input logic [31:0] a, input logic [7:0] g);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_0000 ^ {g, 24'h0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // external bus model: grants after two cycles, inserts gaps between some beats
  initial begin
    forever begin
      @(negedge clk);
      if (ext_req && rst_n) begin
        logic [31:0] a;
        logic [4:0]  n;
        a = ext_addr;
        n = ext_len;
        repeat (2) begin
          @(negedge clk);
          check("R9 hold", {31'd0, ext_req}, 32'd1);
          check("R9 addr", ext_addr, a);
        end
        ext_gnt = 1'b1;
        @(negedge clk);
        ext_gnt = 1'b0;
        ntx++;
        last_addr = a;
        last_len  = n;
        for (int i = 0; i < int'(n); i++) begin
          if (i % 3 == 1) @(negedge clk);
          ext_rvalid = 1'b1;
          ext_rdata  = mem(a + 32'(4 * i), gen);
          @(negedge clk);
          ext_rvalid = 1'b0;
        end
      end
    end
  end

  // monitor: pop expected reads as acknowledges appear
  always @(negedge clk) begin
    if (rst_n && lcl_ack) begin
      acks++;
      if (exp_q.size() == 0) begin
        check("R10 spurious ack", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), lcl_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic rd(input logic [31:0] a, input logic p, input string req);
    @(negedge clk);
    while (lcl_busy) @(negedge clk);
    exp_q.push_back(mem({a[31:2], 2'b00}, gen));
    tag_q.push_back(req);
    reqs++;
    lcl_req  = 1'b1;
    lcl_addr = a;
    lcl_pref = p;
    @(negedge clk);
    lcl_req = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (lcl_busy || exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_pulse();
    lcl_wr_strobe = 1'b1;
    @(negedge clk);
    lcl_wr_strobe = 1'b0;
  endtask

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {31'd0, lcl_busy}, 32'd0);
    check("R1 ack", {31'd0, lcl_ack}, 32'd0);
    check("R1 ext_req", {31'd0, ext_req}, 32'd0);
    rst_n = 1'b1;

    // R1 + R3: first prefetchable read misses, burst at line-aligned address
    base = ntx;
    rd(32'h0000_2048, 1'b1, "R4 mid-line word");
    drain();
    check("R1 first pref misses", 32'(ntx - base), 32'd1);
    check("R3 burst addr", last_addr, 32'h0000_2040);
    check("R3 burst len", {27'd0, last_len}, 32'd16);

    // R5/R6: eight 64-bit reads in the same line, no further external cycle
    base = ntx;
    for (int i = 0; i < 16; i++) rd(32'h0000_2040 + 32'(4 * i), 1'b1, "R5 hit data");
    drain();
    check("R6 one burst per line", 32'(ntx - base), 32'd0);

    // R2: non-prefetchable 64-bit read splits into two single reads
    base = ntx;
    rd(32'h0000_1000, 1'b0, "R2 single data lo");
    rd(32'h0000_1006, 1'b0, "R2 single data hi");
    drain();
    check("R2 two singles", 32'(ntx - base), 32'd2);
    check("R2 single len", {27'd0, last_len}, 32'd1);
    check("R2 word aligned", last_addr, 32'h0000_1004);

    // R7: the non-prefetchable access invalidated line 0x2040
    base = ntx;
    rd(32'h0000_2050, 1'b1, "R7 refetch data");
    drain();
    check("R7 refetch after nonpref", 32'(ntx - base), 32'd1);

    // R6: different line misses, then the old one misses again
    base = ntx;
    rd(32'h0000_20BC, 1'b1, "R4 last word");
    rd(32'h0000_2080, 1'b1, "R5 hit new line");
    rd(32'h0000_2044, 1'b1, "R6 old line data");
    drain();
    check("R6 tag compare", 32'(ntx - base), 32'd2);
    check("R6 line addr", last_addr, 32'h0000_2040);

    // R8: write strobe invalidates; fresh data after refetch
    rd(32'h0000_4000, 1'b1, "R8 fill");
    drain();
    wr_pulse();
    gen = gen + 8'd1;
    base = ntx;
    rd(32'h0000_4004, 1'b1, "R8 fresh data");
    drain();
    check("R8 refetch after write", 32'(ntx - base), 32'd1);

    // R8: write strobe during a fill leaves the line invalid
    base = ntx;
    rd(32'h0000_503C, 1'b1, "R4 wait for last beat");
    repeat (6) @(negedge clk);
    wr_pulse();
    drain();
    rd(32'h0000_5000, 1'b1, "R8 data after killed fill");
    drain();
    check("R8 killed fill refetch", 32'(ntx - base), 32'd2);

    // R10: one ack per request
    check("R10 ack count", 32'(acks), 32'(reqs));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule